// File: doc/BRIEF.md
# Supervisor Special-Register File with Fault Capture

This block holds the supervisor-level special registers of a small processor core. A move-to or move-from instruction supplies a 10-bit register field; the block reassembles the register number from it, then serves a read or a write to the matching register. The registers are the fault address, the fault status, two save/restore registers, four scratch registers and a read-only version value. Decrementer and timebase numbers are also decoded. Their counters live outside this block: a write to one of them leaves as a one-cycle strobe carrying the write data, and a decrementer read returns a value that comes in on a port.

When the load/store unit reports an exception, the block captures the fault address and, depending on the kind of fault, the fault status, without any help from software. A first-fault latch keeps the address of the first faulting access of a multi-access instruction. Any later fault of the same instruction is dropped until the instruction completes. Accesses that cannot be served raise an emulation-exception flag for the core's exception logic.

Top module: `spr_sup_file`

## Requirements
- R1: The register number is `{spr_field[4:0], spr_field[9:5]}`, so the low half of the field gives the number's high five bits. A field sent in unswapped order reaches a different number. For example, field `10'b0100010000` is number 520, which is not decoded.
- R2: Numbers 18 (fault status), 19 (fault address), 26 and 27 (save/restore 0 and 1), and 272 to 275 (scratch 0 to 3) can be read and written. A read returns the value combinationally in the same cycle. A write takes effect at the next clock edge.
- R3: After reset, every register reads zero except number 287, which reads the `PVR_VALUE` parameter. `emu_exc` is low when no access is made.
- R4: A fault report (`lsu_fault_valid`) of any kind loads the fault address with `lsu_fault_ea` at the next edge. Fault kind 2'b00 is a bus error, 2'b01 is an MMU error, 2'b10 is an alignment error and 2'b11 is handled as a bus error. A bus error leaves the fault status unchanged.
- R5: Once one fault has been captured, further faults change neither the fault address nor the fault status until `instr_done` is pulsed. The fault after that is captured.
- R6: An MMU-error fault loads the fault status with `mmu_status`.
- R7: An alignment fault loads the fault status with `align_info`, not with `mmu_status`.
- R8: A read of number 284 or 285 raises `emu_exc` and returns zero data.
- R9: A write to number 287 has no effect and raises no `emu_exc`. The register still reads `PVR_VALUE` afterwards.
- R10: A read or write of a number that is not decoded raises `emu_exc`, returns zero and changes no register.
- R11: If a captured fault and a software write hit the fault address in the same cycle, the fault address takes `lsu_fault_ea`.
- R12: A write to number 22, 284 or 285 pulses `dec_wr`, `tbl_wr` or `tbu_wr` respectively during the write cycle, never more than one at a time. A read of number 22 returns `dec_value`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| spr_field | input | 10 | Register field of the move instruction, halves swapped |
| spr_rd_en | input | 1 | Move-from access this cycle |
| spr_wr_en | input | 1 | Move-to access this cycle |
| spr_wr_data | input | 32 | Write data |
| spr_rd_data | output | 32 | Read data, zero when nothing is read or the access is illegal |
| emu_exc | output | 1 | Illegal access, emulation exception requested |
| lsu_fault_valid | input | 1 | Load/store unit reports a faulting access |
| lsu_fault_kind | input | 2 | Fault kind: 00 bus, 01 MMU, 10 alignment, 11 bus |
| lsu_fault_ea | input | 32 | Effective address of the faulting access |
| mmu_status | input | 32 | Error status from the data MMU |
| align_info | input | 32 | Instruction information for an alignment fault |
| instr_done | input | 1 | Current instruction has completed |
| dec_value | input | 32 | Current decrementer value |
| dec_wr | output | 1 | Decrementer write strobe |
| tbl_wr | output | 1 | Timebase lower write strobe |
| tbu_wr | output | 1 | Timebase upper write strobe |

## Verification
The hardest case to reach is a second fault of the same instruction. It is dropped only because an internal latch is still set, and nothing at the ports shows that latch. The bench reaches it by sending two fault reports on back-to-back cycles, with different addresses and different fault kinds and no completion pulse between them. It then reads the fault address and status back and expects the first report's values. A completion pulse and a third fault then show that the latch clears. The case where a fault and a software write reach the fault address in the same cycle is driven in a single cycle on purpose.

// File: rtl/spr_sup_pkg.sv
package spr_sup_pkg;

    localparam int XLEN        = 32;
    localparam int NUM_SCRATCH = 4;
    localparam int GP_CNT      = 2 + NUM_SCRATCH;
    localparam int GP_IDX_W    = $clog2(GP_CNT);

    localparam logic [9:0] NUM_FSTAT  = 10'd18;
    localparam logic [9:0] NUM_FADDR  = 10'd19;
    localparam logic [9:0] NUM_DEC    = 10'd22;
    localparam logic [9:0] NUM_SAVE0  = 10'd26;
    localparam logic [9:0] NUM_SAVE1  = 10'd27;
    localparam logic [9:0] NUM_SCR0   = 10'd272;
    localparam logic [9:0] NUM_TBLO   = 10'd284;
    localparam logic [9:0] NUM_TBHI   = 10'd285;
    localparam logic [9:0] NUM_VER    = 10'd287;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_FSTAT, SEL_FADDR, SEL_DEC,
        SEL_GP, SEL_TBLO, SEL_TBHI, SEL_VER
    } spr_sel_e;

    typedef enum logic [1:0] {
        FK_BUS   = 2'b00,
        FK_MMU   = 2'b01,
        FK_ALIGN = 2'b10,
        FK_RSVD  = 2'b11
    } fault_kind_e;

    typedef struct packed {
        spr_sel_e              sel;
        logic [GP_IDX_W-1:0]   gp_idx;
    } spr_dec_t;

    typedef struct packed {
        logic                  valid;
        fault_kind_e           kind;
        logic [XLEN-1:0]       ea;
        logic [XLEN-1:0]       mmu;
        logic [XLEN-1:0]       align;
    } fault_rpt_t;

    // The field carries the number's halves swapped.
    function automatic logic [9:0] spr_number(input logic [9:0] field);
        return {field[4:0], field[9:5]};
    endfunction

endpackage

// File: rtl/spr_sup_decode.sv
module spr_sup_decode
    import spr_sup_pkg::*;
(
    input  logic [9:0] spr_field,
    output spr_dec_t   dec
);
    logic [9:0] num;

    always_comb begin
        num        = spr_number(spr_field);
        dec.sel    = SEL_NONE;
        dec.gp_idx = '0;
        if (num >= NUM_SCR0 && num < NUM_SCR0 + 10'(NUM_SCRATCH)) begin
            dec.sel    = SEL_GP;
            dec.gp_idx = GP_IDX_W'(num - NUM_SCR0 + 10'd2);
        end else begin
            case (num)
                NUM_FSTAT: dec.sel = SEL_FSTAT;
                NUM_FADDR: dec.sel = SEL_FADDR;
                NUM_DEC:   dec.sel = SEL_DEC;
                NUM_SAVE0: begin dec.sel = SEL_GP; dec.gp_idx = GP_IDX_W'(0); end
                NUM_SAVE1: begin dec.sel = SEL_GP; dec.gp_idx = GP_IDX_W'(1); end
                NUM_TBLO:  dec.sel = SEL_TBLO;
                NUM_TBHI:  dec.sel = SEL_TBHI;
                NUM_VER:   dec.sel = SEL_VER;
                default:   dec.sel = SEL_NONE;
            endcase
        end
    end
endmodule

// File: rtl/spr_sup_gp_bank.sv
module spr_sup_gp_bank
    import spr_sup_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          we,
    input  logic [GP_IDX_W-1:0]           idx,
    input  logic [XLEN-1:0]               wdata,
    output logic [GP_CNT-1:0][XLEN-1:0]   regs_q
);
    for (genvar g = 0; g < GP_CNT; g++) begin : g_reg
        always_ff @(posedge clk) begin
            if (rst)
                regs_q[g] <= '0;
            else if (we && idx == GP_IDX_W'(g))
                regs_q[g] <= wdata;
        end
    end

    // R2: a register not addressed by a write keeps its value
    p_unaddressed_hold_r2: assert property (@(posedge clk) disable iff (rst)
        (!we || idx != '0) |=> $stable(regs_q[0]));
endmodule

// File: rtl/spr_sup_fault_capture.sv
module spr_sup_fault_capture
    import spr_sup_pkg::*;
(
    input  logic             clk,
    input  logic             rst,
    input  fault_rpt_t       rpt,
    input  logic             instr_done,
    input  logic             sw_faddr_we,
    input  logic             sw_fstat_we,
    input  logic [XLEN-1:0]  sw_data,
    output logic [XLEN-1:0]  faddr_q,
    output logic [XLEN-1:0]  fstat_q
);
    logic first_q;
    logic take;

    assign take = rpt.valid && !first_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            first_q <= 1'b0;
            faddr_q <= '0;
            fstat_q <= '0;
        end else begin
            first_q <= instr_done ? 1'b0 : (first_q | take);
            if (take)
                faddr_q <= rpt.ea;
            else if (sw_faddr_we)
                faddr_q <= sw_data;
            if (take && rpt.kind == FK_MMU)
                fstat_q <= rpt.mmu;
            else if (take && rpt.kind == FK_ALIGN)
                fstat_q <= rpt.align;
            else if (sw_fstat_we)
                fstat_q <= sw_data;
        end
    end

    p_fault_loads_addr_r4: assert property (@(posedge clk) disable iff (rst)
        take |=> faddr_q == $past(rpt.ea));

    p_later_fault_dropped_r5: assert property (@(posedge clk) disable iff (rst)
        (first_q && !sw_faddr_we) |=> $stable(faddr_q));

    p_capture_beats_write_r11: assert property (@(posedge clk) disable iff (rst)
        (take && sw_faddr_we) |=> faddr_q == $past(rpt.ea));
endmodule

// File: rtl/spr_sup_file.sv
module spr_sup_file
    import spr_sup_pkg::*;
#(
    parameter logic [31:0] PVR_VALUE = 32'h0050_0000
) (
    input  logic        clk,
    input  logic        rst,
    input  logic [9:0]  spr_field,
    input  logic        spr_rd_en,
    input  logic        spr_wr_en,
    input  logic [31:0] spr_wr_data,
    output logic [31:0] spr_rd_data,
    output logic        emu_exc,
    input  logic        lsu_fault_valid,
    input  logic [1:0]  lsu_fault_kind,
    input  logic [31:0] lsu_fault_ea,
    input  logic [31:0] mmu_status,
    input  logic [31:0] align_info,
    input  logic        instr_done,
    input  logic [31:0] dec_value,
    output logic        dec_wr,
    output logic        tbl_wr,
    output logic        tbu_wr
);
    spr_dec_t                     dec;
    fault_rpt_t                   rpt;
    logic                         wr_ok;
    logic                         bad_rd;
    logic [GP_CNT-1:0][XLEN-1:0]  gp_q;
    logic [XLEN-1:0]              faddr_q;
    logic [XLEN-1:0]              fstat_q;

    spr_sup_decode u_dec (
        .spr_field (spr_field),
        .dec       (dec)
    );

    always_comb begin
        rpt.valid = lsu_fault_valid;
        rpt.kind  = fault_kind_e'(lsu_fault_kind);
        rpt.ea    = lsu_fault_ea;
        rpt.mmu   = mmu_status;
        rpt.align = align_info;
    end

    assign bad_rd  = spr_rd_en && (dec.sel == SEL_NONE || dec.sel == SEL_TBLO
                                   || dec.sel == SEL_TBHI);
    assign emu_exc = bad_rd || (spr_wr_en && dec.sel == SEL_NONE);
    assign wr_ok   = spr_wr_en && dec.sel != SEL_NONE && dec.sel != SEL_VER;
    assign dec_wr  = wr_ok && dec.sel == SEL_DEC;
    assign tbl_wr  = wr_ok && dec.sel == SEL_TBLO;
    assign tbu_wr  = wr_ok && dec.sel == SEL_TBHI;

    spr_sup_gp_bank u_bank (
        .clk    (clk),
        .rst    (rst),
        .we     (wr_ok && dec.sel == SEL_GP),
        .idx    (dec.gp_idx),
        .wdata  (spr_wr_data),
        .regs_q (gp_q)
    );

    spr_sup_fault_capture u_fault (
        .clk         (clk),
        .rst         (rst),
        .rpt         (rpt),
        .instr_done  (instr_done),
        .sw_faddr_we (wr_ok && dec.sel == SEL_FADDR),
        .sw_fstat_we (wr_ok && dec.sel == SEL_FSTAT),
        .sw_data     (spr_wr_data),
        .faddr_q     (faddr_q),
        .fstat_q     (fstat_q)
    );

    always_comb begin
        spr_rd_data = '0;
        if (spr_rd_en && !bad_rd) begin
            case (dec.sel)
                SEL_FSTAT: spr_rd_data = fstat_q;
                SEL_FADDR: spr_rd_data = faddr_q;
                SEL_DEC:   spr_rd_data = dec_value;
                SEL_GP:    spr_rd_data = gp_q[dec.gp_idx];
                SEL_VER:   spr_rd_data = PVR_VALUE;
                default:   spr_rd_data = '0;
            endcase
        end
    end

    p_illegal_no_data_r8: assert property (@(posedge clk) disable iff (rst)
        emu_exc |-> spr_rd_data == '0);

    p_strobe_onehot_r12: assert property (@(posedge clk) disable iff (rst)
        $onehot0({dec_wr, tbl_wr, tbu_wr}));

    p_version_no_exc_r9: assert property (@(posedge clk) disable iff (rst)
        (spr_wr_en && !spr_rd_en && dec.sel == SEL_VER) |-> !emu_exc);
endmodule

// File: tb/spr_sup_file_tb_top.sv
module spr_sup_file_tb_top;
    localparam logic [31:0] PVR = 32'h0050_0000;

    logic        clk = 1'b0;
    logic        rst;
    logic [9:0]  spr_field;
    logic        spr_rd_en, spr_wr_en;
    logic [31:0] spr_wr_data, spr_rd_data;
    logic        emu_exc;
    logic        lsu_fault_valid;
    logic [1:0]  lsu_fault_kind;
    logic [31:0] lsu_fault_ea, mmu_status, align_info;
    logic        instr_done;
    logic [31:0] dec_value;
    logic        dec_wr, tbl_wr, tbu_wr;

    int n_checks = 0;
    int n_errors = 0;

    always #10 clk = ~clk;

    spr_sup_file #(.PVR_VALUE(PVR)) dut_i (
        .clk(clk), .rst(rst), .spr_field(spr_field), .spr_rd_en(spr_rd_en),
        .spr_wr_en(spr_wr_en), .spr_wr_data(spr_wr_data), .spr_rd_data(spr_rd_data),
        .emu_exc(emu_exc), .lsu_fault_valid(lsu_fault_valid),
        .lsu_fault_kind(lsu_fault_kind), .lsu_fault_ea(lsu_fault_ea),
        .mmu_status(mmu_status), .align_info(align_info), .instr_done(instr_done),
        .dec_value(dec_value), .dec_wr(dec_wr), .tbl_wr(tbl_wr), .tbu_wr(tbu_wr)
    );

    function automatic logic [9:0] fld(input logic [9:0] num);
        return {num[4:0], num[9:5]};
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_errors++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic sw_write(input logic [9:0] num, input logic [31:0] d);
        @(negedge clk);
        spr_field = fld(num); spr_wr_data = d; spr_wr_en = 1'b1;
        @(negedge clk);
        spr_wr_en = 1'b0;
    endtask

    task automatic sw_read_raw(input logic [9:0] f, output logic [31:0] d, output logic e);
        @(negedge clk);
        spr_field = f; spr_rd_en = 1'b1;
        #2;
        d = spr_rd_data; e = emu_exc;
        spr_rd_en = 1'b0;
    endtask

    task automatic sw_read(input logic [9:0] num, output logic [31:0] d, output logic e);
        sw_read_raw(fld(num), d, e);
    endtask

    task automatic fault(input logic [1:0] k, input logic [31:0] ea,
                         input logic [31:0] ms, input logic [31:0] ai);
        @(negedge clk);
        lsu_fault_valid = 1'b1; lsu_fault_kind = k; lsu_fault_ea = ea;
        mmu_status = ms; align_info = ai;
        @(negedge clk);
        lsu_fault_valid = 1'b0;
    endtask

    task automatic done_pulse();
        @(negedge clk);
        instr_done = 1'b1;
        @(negedge clk);
        instr_done = 1'b0;
    endtask

    task automatic t_reset();
        logic [31:0] d; logic e;
        sw_read(10'd19, d, e);  check("R3 faddr reset", d, 32'h0);
        check("R3 no exc", {31'b0, e}, 32'h0);
        sw_read(10'd18, d, e);  check("R3 fstat reset", d, 32'h0);
        sw_read(10'd26, d, e);  check("R3 save0 reset", d, 32'h0);
        sw_read(10'd275, d, e); check("R3 scratch3 reset", d, 32'h0);
        sw_read(10'd287, d, e); check("R3 version reset", d, PVR);
    endtask

    task automatic t_gp_rw();
        logic [31:0] d; logic e;
        logic [9:0] nums [6] = '{10'd26, 10'd27, 10'd272, 10'd273, 10'd274, 10'd275};
        for (int i = 0; i < 6; i++) sw_write(nums[i], 32'hA000_0000 + i);
        for (int i = 0; i < 6; i++) begin
            sw_read(nums[i], d, e);
            check("R2 gp readback", d, 32'hA000_0000 + i);
        end
        sw_write(10'd19, 32'h1111_2222); sw_read(10'd19, d, e);
        check("R2 faddr sw write", d, 32'h1111_2222);
        sw_write(10'd18, 32'h3333_4444); sw_read(10'd18, d, e);
        check("R2 fstat sw write", d, 32'h3333_4444);
    endtask

    task automatic t_swap();
        logic [31:0] d; logic e;
        sw_read_raw(10'b10000_01000, d, e);
        check("R1 swapped field reaches scratch0", d, 32'hA000_0002);
        sw_read_raw(10'b01000_10000, d, e);
        check("R1 unswapped field is illegal", {31'b0, e}, 32'h1);
        check("R1 unswapped field no data", d, 32'h0);
    endtask

    task automatic t_bus();
        logic [31:0] d; logic e;
        done_pulse();
        fault(2'b00, 32'hB000_0010, 32'hDEAD_0001, 32'hDEAD_0002);
        sw_read(10'd19, d, e); check("R4 bus fault address", d, 32'hB000_0010);
        sw_read(10'd18, d, e); check("R4 bus fault keeps status", d, 32'h3333_4444);
    endtask

    task automatic t_first();
        logic [31:0] d; logic e;
        done_pulse();
        @(negedge clk);
        lsu_fault_valid = 1'b1; lsu_fault_kind = 2'b00; lsu_fault_ea = 32'hC000_0001;
        mmu_status = 32'h0; align_info = 32'h0;
        @(negedge clk);
        lsu_fault_kind = 2'b01; lsu_fault_ea = 32'hC000_0002; mmu_status = 32'h0BAD_0BAD;
        @(negedge clk);
        lsu_fault_valid = 1'b0;
        sw_read(10'd19, d, e); check("R5 first address kept", d, 32'hC000_0001);
        sw_read(10'd18, d, e); check("R5 second status dropped", d, 32'h3333_4444);
        done_pulse();
        fault(2'b01, 32'hC000_0003, 32'h0000_5A5A, 32'h0);
        sw_read(10'd19, d, e); check("R5 after done recaptured", d, 32'hC000_0003);
        sw_read(10'd18, d, e); check("R6 mmu status", d, 32'h0000_5A5A);
    endtask

    task automatic t_align();
        logic [31:0] d; logic e;
        done_pulse();
        fault(2'b10, 32'hD000_0004, 32'h7777_7777, 32'h0000_ABCD);
        sw_read(10'd18, d, e); check("R7 align info", d, 32'h0000_ABCD);
        sw_read(10'd19, d, e); check("R7 align address", d, 32'hD000_0004);
    endtask

    task automatic t_timebase();
        logic [31:0] d; logic e;
        sw_read(10'd284, d, e);
        check("R8 tb lower read exc", {31'b0, e}, 32'h1); check("R8 tb lower data", d, 32'h0);
        sw_read(10'd285, d, e);
        check("R8 tb upper read exc", {31'b0, e}, 32'h1);
        @(negedge clk);
        spr_field = fld(10'd284); spr_wr_data = 32'h1; spr_wr_en = 1'b1;
        #2;
        check("R12 tbl strobe", {29'b0, dec_wr, tbl_wr, tbu_wr}, 32'h2);
        check("R12 tb write no exc", {31'b0, emu_exc}, 32'h0);
        spr_field = fld(10'd22);
        #2;
        check("R12 dec strobe", {29'b0, dec_wr, tbl_wr, tbu_wr}, 32'h4);
        spr_field = fld(10'd285);
        #2;
        check("R12 tbu strobe", {29'b0, dec_wr, tbl_wr, tbu_wr}, 32'h1);
        @(negedge clk);
        spr_wr_en = 1'b0;
        #2;
        check("R12 strobes idle", {29'b0, dec_wr, tbl_wr, tbu_wr}, 32'h0);
        dec_value = 32'h0000_0F0F;
        sw_read(10'd22, d, e); check("R12 dec read", d, 32'h0000_0F0F);
    endtask

    task automatic t_version();
        logic [31:0] d; logic e;
        @(negedge clk);
        spr_field = fld(10'd287); spr_wr_data = 32'hFFFF_FFFF; spr_wr_en = 1'b1;
        #2;
        check("R9 version write no exc", {31'b0, emu_exc}, 32'h0);
        @(negedge clk);
        spr_wr_en = 1'b0;
        sw_read(10'd287, d, e); check("R9 version unchanged", d, PVR);
    endtask

    task automatic t_undecoded();
        logic [31:0] d; logic e;
        @(negedge clk);
        spr_field = fld(10'd100); spr_wr_data = 32'h9999_9999; spr_wr_en = 1'b1;
        #2;
        check("R10 undecoded write exc", {31'b0, emu_exc}, 32'h1);
        @(negedge clk);
        spr_wr_en = 1'b0;
        sw_read(10'd100, d, e);
        check("R10 undecoded read exc", {31'b0, e}, 32'h1);
        check("R10 undecoded read data", d, 32'h0);
        for (int i = 0; i < 4; i++) begin
            sw_read(10'd272 + 10'(i), d, e);
            check("R10 scratch unchanged", d, 32'hA000_0002 + i);
        end
        sw_read(10'd27, d, e); check("R10 save1 unchanged", d, 32'hA000_0001);
    endtask

    task automatic t_priority();
        logic [31:0] d; logic e;
        done_pulse();
        @(negedge clk);
        spr_field = fld(10'd19); spr_wr_data = 32'h5555_5555; spr_wr_en = 1'b1;
        lsu_fault_valid = 1'b1; lsu_fault_kind = 2'b00; lsu_fault_ea = 32'hE000_00E0;
        @(negedge clk);
        spr_wr_en = 1'b0; lsu_fault_valid = 1'b0;
        sw_read(10'd19, d, e); check("R11 capture wins", d, 32'hE000_00E0);
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_checks++; n_errors++;
        $display("FAIL watchdog: actual=running expected=finished");
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end

    initial begin
        rst = 1'b1; spr_field = '0; spr_rd_en = 1'b0; spr_wr_en = 1'b0;
        spr_wr_data = '0; lsu_fault_valid = 1'b0; lsu_fault_kind = '0;
        lsu_fault_ea = '0; mmu_status = '0; align_info = '0; instr_done = 1'b0;
        dec_value = '0;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_gp_rw();
        t_swap();
        t_bus();
        t_first();
        t_align();
        t_timebase();
        t_version();
        t_undecoded();
        t_priority();
        $display("Result: errors=%0d of %0d checks", n_errors, n_checks);
        $finish;
    end
endmodule